// File: doc/BRIEF.md
# High-Speed Chirp Handshake Controller (Device Side)

This block runs the device end of the speed negotiation that takes place while the bus is held in reset. A transceiver model gives it a decoded two-bit line state and a reset cue. The cue is high while the bus looks as if it may be in reset: a single-ended zero seen in full-speed operation, or a squelched, silent bus seen in high-speed operation. The block drives the D+ pull-up enable, the high-speed termination enable and the chirp-K transmit enable. It also reports its operating mode, the speed it negotiated and a one-cycle completion pulse.

When the reset cue is held long enough, the block moves the transceiver to full-speed configuration and waits for the line to settle. It then samples the line, and only a single-ended zero leads on to its own chirp K. After the chirp it listens for the hub's alternating K/J chirps. The block measures how long each segment lasts and counts the ones that alternate correctly. Enough valid segments in a row move it into high-speed mode. If the listening window expires first, it falls back to full speed. When the device was running at high speed, a bus that is still not in single-ended zero after the settle time is read as suspend, not reset.

All durations are given in microseconds and scaled to clock cycles through a clock-frequency parameter in kHz.

Top module: `hs_chirp_ctrl`

## Requirements
- R1: The reset cue must stay high for the whole reset-wait time (default 3060 µs). The block then switches to full-speed configuration: pull-up on, termination off. If the cue drops earlier, the block returns to the configuration it started from, and no chirp is sent. The pull-up and the termination are never both on.
- R2: After the switch to full speed, the block waits a settle time and then samples the line: 200 µs when coming from full speed or suspend, 500 µs when coming from high speed. A line of 2'b00 (SE0) starts the chirp. Any other value leads to suspend if the block came from high speed, and back to full speed otherwise.
- R3: Chirp-K enable stays high for exactly the chirp time (default 1500 µs). During the chirp the pull-up is on, the termination is off and the mode is full speed.
- R4: Line states are encoded as 00 = SE0, 01 = J, 10 = K and 11 = invalid. The hub chirp is recognised when six consecutive segments have been seen in the order K, J, K, J, K, J. Each segment must last between 40 and 60 µs inclusive. A segment is counted when the line changes away from it.
- R5: A segment that is shorter than 40 µs or longer than 60 µs, or one that is SE0, invalid or out of order, clears the count to zero. A valid K starts a new count.
- R6: Once the hub chirp is recognised, the block waits a high-speed entry delay (default 100 µs, at most 500 µs). It then turns the termination on and the pull-up off, switches to high-speed mode and sets the negotiated-speed output to 1.
- R7: If no hub chirp is recognised within the listening window (default 3000 µs from the end of the chirp), the block returns to full-speed mode and clears the negotiated-speed output.
- R8: From the start of the chirp until the final mode is reached, the mode output shows full speed and never suspend, whatever hub chirp activity is on the line.
- R9: The done output pulses for exactly one cycle, in the first cycle in which the final mode (high speed or the full-speed fallback) appears. In that cycle the negotiated-speed output already agrees with the mode.
- R10: The mode is encoded as 0 = suspend, 1 = full speed, 2 = high speed, and the value 3 never appears. After a synchronous reset the block is in full-speed mode, with the pull-up on, the termination off, the chirp off, the negotiated speed at 0 and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_st | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 invalid |
| rst_cue | input | 1 | High while the bus looks as if it may be in reset |
| pullup_en | output | 1 | D+ pull-up enable |
| hs_term_en | output | 1 | High-speed termination enable |
| chirp_k_en | output | 1 | Transmit chirp K |
| op_mode | output | 2 | 0 suspend, 1 full speed, 2 high speed |
| neg_hs | output | 1 | Negotiated speed of the last handshake: 1 high speed, 0 full speed |
| hs_done | output | 1 | One-cycle pulse when the handshake finishes |

## Verification
A wrong state or phase timer shows up on the pull-up, termination and chirp pins in the same cycle the error happens. The reason is that these pins decode the state register directly. A chirp that starts or stops one cycle off, or a settle sample taken one cycle early, is therefore caught on the next clock comparison. A wrong segment count inside the chirp meter stays hidden until it would have changed the outcome. It surfaces either as a high-speed entry one entry-delay after a sequence the bench counts as invalid, or as a missing entry. The bench applies exact boundary segment lengths (39, 40, 60 and 61 cycles) and a mid-sequence glitch to the invalid code so that such errors change the outcome.

// File: rtl/hs_chirp_pkg.sv
// Package: shared types and helpers for the chirp handshake controller.
// Assumes line states arrive already decoded by a transceiver model.
package hs_chirp_pkg;

    // Decoded line state (encoding fixed by the requirements)
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_BAD = 2'b11
    } line_e;

    // Operating mode reported at the port
    typedef enum logic [1:0] {
        OM_SUSP = 2'd0,
        OM_FS   = 2'd1,
        OM_HS   = 2'd2
    } opmode_e;

    // Controller phases
    typedef enum logic [2:0] {
        ST_FS,
        ST_HS,
        ST_SUSP,
        ST_WAIT,
        ST_SETTLE,
        ST_CHIRP,
        ST_LISTEN,
        ST_HSGO
    } cst_e;

    // Convert microseconds to clock cycles for a clock given in kHz
    function automatic int us2cyc(input int khz, input int us);
        return (khz * us) / 1000;
    endfunction

    // Larger of two integers, used to size counters
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chirp_phase_timer.sv
// Module: phase timer. Counts cycles spent in the current controller phase.
// Assumes restart is asserted in the cycle before a new phase begins, so the
// count reads zero in the first cycle of every phase. Saturates at all-ones.
module chirp_phase_timer #(
    parameter int TW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [TW-1:0] cnt
);

    localparam logic [TW-1:0] CNT_TOP = {TW{1'b1}};

    // Phase cycle counter with restart and saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != CNT_TOP) begin
            cnt <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/chirp_kj_meter.sv
// Module: hub chirp meter. Measures the length of each line-state segment
// and counts consecutive in-bounds segments that alternate K, J, K, J...
// The meter only runs while arm is high; otherwise it holds a cleared state.
// A segment is judged in the cycle the line changes away from it.
// hit is raised in the cycle the NEED-th valid segment completes.
module chirp_kj_meter
    import hs_chirp_pkg::*;
#(
    parameter int SEG_MIN = 40,
    parameter int SEG_MAX = 60,
    parameter int NEED    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic [1:0] line_st,
    output logic       hit
);

    localparam int LW = $clog2(SEG_MAX + 2);
    localparam int CW = $clog2(NEED + 1);
    localparam logic [LW-1:0] L_MIN = LW'(SEG_MIN);
    localparam logic [LW-1:0] L_MAX = LW'(SEG_MAX);
    localparam logic [LW-1:0] L_CAP = LW'(SEG_MAX + 1);
    localparam logic [CW-1:0] C_LAST = CW'(NEED - 1);

    logic [1:0]    prev_ls;
    logic [LW-1:0] seg_len;
    logic [CW-1:0] kj_cnt;
    logic          changed;
    logic [1:0]    want_ls;
    logic          seg_ok;

    // Judge the segment that ends in this cycle
    always_comb begin
        changed = (line_st != prev_ls);
        want_ls = kj_cnt[0] ? LS_J : LS_K;
        seg_ok  = (prev_ls == want_ls) && (seg_len >= L_MIN) && (seg_len <= L_MAX);
        hit     = arm && changed && seg_ok && (kj_cnt == C_LAST);
    end

    // Segment length and alternation count
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            prev_ls <= LS_SE0;
            seg_len <= '0;
            kj_cnt  <= '0;
        end else if (changed) begin
            kj_cnt  <= seg_ok ? (kj_cnt + CW'(1)) : '0;
            prev_ls <= line_st;
            seg_len <= LW'(1);
        end else if (seg_len != L_CAP) begin
            seg_len <= seg_len + LW'(1);
        end
    end

endmodule

// File: rtl/chirp_seq_fsm.sv
// Module: handshake sequencer. Steps through reset wait, full-speed switch,
// settle and sample, chirp K, hub chirp listening and high-speed entry.
// The transceiver controls are decoded from the state as Moore outputs.
// Assumes every phase length is at least one cycle.
module chirp_seq_fsm
    import hs_chirp_pkg::*;
#(
    parameter int TW         = 18,
    parameter int WAIT_CYC   = 3060,
    parameter int FSSAMP_CYC = 200,
    parameter int HSSET_CYC  = 500,
    parameter int CHIRP_CYC  = 1500,
    parameter int LISTEN_CYC = 3000,
    parameter int HSGO_CYC   = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    line_st,
    input  logic          rst_cue,
    input  logic          hit,
    input  logic [TW-1:0] tcnt,
    output logic          restart,
    output logic          listening,
    output logic          pullup_en,
    output logic          hs_term_en,
    output logic          chirp_k_en,
    output logic [1:0]    op_mode,
    output logic          hs_done,
    output logic          neg_hs
);

    localparam logic [TW-1:0] E_WAIT   = TW'(WAIT_CYC - 1);
    localparam logic [TW-1:0] E_FSSAMP = TW'(FSSAMP_CYC - 1);
    localparam logic [TW-1:0] E_HSSET  = TW'(HSSET_CYC - 1);
    localparam logic [TW-1:0] E_CHIRP  = TW'(CHIRP_CYC - 1);
    localparam logic [TW-1:0] E_LISTEN = TW'(LISTEN_CYC - 1);
    localparam logic [TW-1:0] E_HSGO   = TW'(HSGO_CYC - 1);

    cst_e state, nstate;
    logic orig_hs;
    logic fin_hs, fin_fs;
    logic in_hs_cfg;

    // Next-phase selection
    always_comb begin
        nstate = state;
        unique case (state)
            ST_FS, ST_SUSP, ST_HS: begin
                if (rst_cue) nstate = ST_WAIT;
            end
            ST_WAIT: begin
                if (!rst_cue)           nstate = orig_hs ? ST_HS : ST_FS;
                else if (tcnt == E_WAIT) nstate = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tcnt == (orig_hs ? E_HSSET : E_FSSAMP)) begin
                    if (line_st == LS_SE0) nstate = ST_CHIRP;
                    else                   nstate = orig_hs ? ST_SUSP : ST_FS;
                end
            end
            ST_CHIRP: begin
                if (tcnt == E_CHIRP) nstate = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (hit)                   nstate = ST_HSGO;
                else if (tcnt == E_LISTEN) nstate = ST_FS;
            end
            ST_HSGO: begin
                if (tcnt == E_HSGO) nstate = ST_HS;
            end
            default: nstate = ST_FS;
        endcase
        restart = (nstate != state);
        fin_hs  = (state == ST_HSGO) && (nstate == ST_HS);
        fin_fs  = (state == ST_LISTEN) && (nstate == ST_FS);
    end

    // Phase register, origin speed and handshake result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FS;
            orig_hs <= 1'b0;
            hs_done <= 1'b0;
            neg_hs  <= 1'b0;
        end else begin
            state <= nstate;
            if ((state == ST_FS || state == ST_HS || state == ST_SUSP) && nstate == ST_WAIT)
                orig_hs <= (state == ST_HS);
            hs_done <= fin_hs || fin_fs;
            if (fin_hs) neg_hs <= 1'b1;
            else if (fin_fs) neg_hs <= 1'b0;
        end
    end

    // Transceiver controls and mode decoded from the phase
    always_comb begin
        in_hs_cfg  = (state == ST_HS) || (state == ST_WAIT && orig_hs);
        pullup_en  = !in_hs_cfg;
        hs_term_en = in_hs_cfg;
        chirp_k_en = (state == ST_CHIRP);
        listening  = (state == ST_LISTEN);
        if (in_hs_cfg)             op_mode = OM_HS;
        else if (state == ST_SUSP) op_mode = OM_SUSP;
        else                       op_mode = OM_FS;
    end

endmodule

// File: rtl/hs_chirp_ctrl.sv
// Module: device-side high-speed chirp handshake controller (top).
// Scales the microsecond timing parameters to cycles and ties together the
// phase timer, the hub chirp meter and the sequencer.
// Assumes CLK_KHZ gives at least one cycle for every duration.
module hs_chirp_ctrl
    import hs_chirp_pkg::*;
#(
    parameter int CLK_KHZ      = 60000,
    parameter int WAIT_US      = 3060,
    parameter int FS_SAMPLE_US = 200,
    parameter int HS_SETTLE_US = 500,
    parameter int CHIRP_US     = 1500,
    parameter int SEG_MIN_US   = 40,
    parameter int SEG_MAX_US   = 60,
    parameter int KJ_NEED      = 6,
    parameter int LISTEN_US    = 3000,
    parameter int HS_ENTER_US  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic       rst_cue,
    output logic       pullup_en,
    output logic       hs_term_en,
    output logic       chirp_k_en,
    output logic [1:0] op_mode,
    output logic       neg_hs,
    output logic       hs_done
);

    localparam int WAIT_CYC   = us2cyc(CLK_KHZ, WAIT_US);
    localparam int FSSAMP_CYC = us2cyc(CLK_KHZ, FS_SAMPLE_US);
    localparam int HSSET_CYC  = us2cyc(CLK_KHZ, HS_SETTLE_US);
    localparam int CHIRP_CYC  = us2cyc(CLK_KHZ, CHIRP_US);
    localparam int SMIN_CYC   = us2cyc(CLK_KHZ, SEG_MIN_US);
    localparam int SMAX_CYC   = us2cyc(CLK_KHZ, SEG_MAX_US);
    localparam int LISTEN_CYC = us2cyc(CLK_KHZ, LISTEN_US);
    localparam int HSGO_CYC   = us2cyc(CLK_KHZ, HS_ENTER_US);
    localparam int MAX_CYC    = imax(imax(imax(WAIT_CYC, FSSAMP_CYC), imax(HSSET_CYC, CHIRP_CYC)),
                                     imax(LISTEN_CYC, HSGO_CYC));
    localparam int TW         = $clog2(MAX_CYC + 1);

    logic          restart;
    logic          listening;
    logic          hit;
    logic [TW-1:0] tcnt;

    chirp_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt     (tcnt)
    );

    chirp_kj_meter #(
        .SEG_MIN (SMIN_CYC),
        .SEG_MAX (SMAX_CYC),
        .NEED    (KJ_NEED)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (listening),
        .line_st (line_st),
        .hit     (hit)
    );

    chirp_seq_fsm #(
        .TW         (TW),
        .WAIT_CYC   (WAIT_CYC),
        .FSSAMP_CYC (FSSAMP_CYC),
        .HSSET_CYC  (HSSET_CYC),
        .CHIRP_CYC  (CHIRP_CYC),
        .LISTEN_CYC (LISTEN_CYC),
        .HSGO_CYC   (HSGO_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_st    (line_st),
        .rst_cue    (rst_cue),
        .hit        (hit),
        .tcnt       (tcnt),
        .restart    (restart),
        .listening  (listening),
        .pullup_en  (pullup_en),
        .hs_term_en (hs_term_en),
        .chirp_k_en (chirp_k_en),
        .op_mode    (op_mode),
        .hs_done    (hs_done),
        .neg_hs     (neg_hs)
    );

endmodule

// File: rtl/hs_chirp_chk.sv
// Module: property checker for the chirp handshake controller, bound to the
// top. Observes only the top-level ports, plus a chirp run counter of its own.
module hs_chirp_chk #(
    parameter int CHIRP_CYC = 1500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pullup_en,
    input logic       hs_term_en,
    input logic       chirp_k_en,
    input logic [1:0] op_mode,
    input logic       neg_hs,
    input logic       hs_done
);

    logic [31:0] clen;

    // Count consecutive chirp cycles before the current one
    always_ff @(posedge clk) begin
        if (!rst_n)          clen <= '0;
        else if (chirp_k_en) clen <= clen + 32'd1;
        else                 clen <= '0;
    end

    AST_PU_TERM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> !hs_term_en); // R1
    AST_CHIRP_FS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_k_en |-> (pullup_en && !hs_term_en && op_mode == 2'd1)); // R3
    AST_CHIRP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_k_en |-> (clen < 32'(CHIRP_CYC))); // R3
    AST_HS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'd2) |-> (hs_term_en && !pullup_en)); // R6
    AST_CHIRP_END_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chirp_k_en) |-> (op_mode == 2'd1 && pullup_en)); // R8
    AST_DONE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        hs_done |=> !hs_done); // R9
    AST_DONE_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        hs_done |-> (neg_hs == (op_mode == 2'd2) && op_mode != 2'd0)); // R9
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_mode != 2'd3); // R10

endmodule

bind hs_chirp_ctrl hs_chirp_chk #(.CHIRP_CYC(CHIRP_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pullup_en  (pullup_en),
    .hs_term_en (hs_term_en),
    .chirp_k_en (chirp_k_en),
    .op_mode    (op_mode),
    .neg_hs     (neg_hs),
    .hs_done    (hs_done)
);

// File: tb/sim_hs_chirp_ctrl.sv
// Bench: a behavioural reference model advanced on every rising edge and
// compared with the ports on every falling edge, plus directed end checks.
module sim_hs_chirp_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WC = 3060, FSS = 200, HSS = 500, CH = 1500;
    localparam int LI = 3000, HG = 100, SMIN = 40, SMAX = 60, NEED = 6;
    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, BAD = 2'b11;
    localparam int P_FS = 0, P_HS = 1, P_SUSP = 2, P_WAIT = 3;
    localparam int P_SET = 4, P_CHIRP = 5, P_LIST = 6, P_HSGO = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_st = SE0;
    logic       rst_cue = 1'b0;
    logic       pullup_en, hs_term_en, chirp_k_en, neg_hs, hs_done;
    logic [1:0] op_mode;

    int checks = 0;
    int fails = 0;
    bit live = 0;

    // reference model state
    int ph = P_FS, t = 0, sv = 0, sl = 0, run = 0;
    bit fh = 0, e_done = 0, e_neg = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_chirp_ctrl #(.CLK_KHZ(1000)) u0 (
        .clk(clk), .rst_n(rst_n), .line_st(line_st), .rst_cue(rst_cue),
        .pullup_en(pullup_en), .hs_term_en(hs_term_en), .chirp_k_en(chirp_k_en),
        .op_mode(op_mode), .neg_hs(neg_hs), .hs_done(hs_done)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Reference model: one step per rising edge, from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = P_FS; t = 0; fh = 0; e_done = 0; e_neg = 0; sv = 0; sl = 0; run = 0;
        end else begin
            int nph;
            bit hit, fin, ok;
            nph = ph; hit = 0; fin = 0;
            if (ph == P_LIST) begin
                if (int'(line_st) == sv) begin
                    if (sl < 1000) sl++;
                end else begin
                    ok = (((run % 2) == 0 && sv == int'(K)) || ((run % 2) == 1 && sv == int'(J)))
                         && sl >= SMIN && sl <= SMAX;
                    run = ok ? run + 1 : 0;
                    if (run == NEED) hit = 1;
                    sv = int'(line_st); sl = 1;
                end
            end else begin
                sv = 0; sl = 0; run = 0;
            end
            case (ph)
                P_FS, P_SUSP: if (rst_cue) begin nph = P_WAIT; fh = 0; end
                P_HS:         if (rst_cue) begin nph = P_WAIT; fh = 1; end
                P_WAIT: begin
                    if (!rst_cue) nph = fh ? P_HS : P_FS;
                    else if (t + 1 == WC) nph = P_SET;
                end
                P_SET: if (t + 1 == (fh ? HSS : FSS))
                           nph = (line_st == SE0) ? P_CHIRP : (fh ? P_SUSP : P_FS);
                P_CHIRP: if (t + 1 == CH) nph = P_LIST;
                P_LIST: begin
                    if (hit) nph = P_HSGO;
                    else if (t + 1 == LI) begin nph = P_FS; fin = 1; e_neg = 0; end
                end
                P_HSGO: if (t + 1 == HG) begin nph = P_HS; fin = 1; e_neg = 1; end
                default: nph = P_FS;
            endcase
            e_done = fin;
            t = (nph == ph) ? t + 1 : 0;
            ph = nph;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            bit hsc;
            int em;
            hsc = (ph == P_HS) || (ph == P_WAIT && fh);
            em  = hsc ? 2 : (ph == P_SUSP ? 0 : 1);
            cmp("R1 pullup_en", pullup_en, !hsc);
            cmp("R1 hs_term_en", hs_term_en, hsc);
            cmp("R3 chirp_k_en", chirp_k_en, ph == P_CHIRP);
            cmp("R8 op_mode", op_mode, em);
            cmp("R9 hs_done", hs_done, e_done);
            cmp("R6 neg_hs", neg_hs, e_neg);
        end
    end

    task automatic drive(input logic [1:0] ls, input logic cue, input int n);
        line_st = ls;
        rst_cue = cue;
        repeat (n) @(negedge clk);
    endtask

    task automatic hub_pairs(input int n, input int len);
        for (int i = 0; i < n; i++) begin
            drive(K, 1'b0, len);
            drive(J, 1'b0, len);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        // R10: state after reset
        cmp("R10 reset mode", op_mode, 1);
        cmp("R10 reset pullup", pullup_en, 1);
        cmp("R10 reset neg_hs", neg_hs, 0);
        drive(J, 1'b0, 20);

        // Full speed to high speed, plain 50-cycle hub chirps (R2, R4, R6)
        drive(SE0, 1'b1, WC + 250);
        drive(K, 1'b0, 1400);
        drive(SE0, 1'b0, 100);
        hub_pairs(4, 50);
        drive(SE0, 1'b0, 300);
        cmp("R4 hub chirp recognised", op_mode, 2);
        cmp("R6 neg_hs after HS entry", neg_hs, 1);

        // From high speed, bus goes idle J after the wait: suspend (R2)
        drive(SE0, 1'b1, WC + 100);
        drive(J, 1'b0, 600);
        cmp("R2 HS origin non-SE0 sample gives suspend", op_mode, 0);
        drive(J, 1'b0, 20);

        // From suspend: broken chirp sequences, then timeout (R5, R7)
        drive(SE0, 1'b1, WC + 250);
        drive(K, 1'b0, 1400);
        drive(SE0, 1'b0, 100);
        drive(K, 1'b0, 50); drive(J, 1'b0, 50); drive(K, 1'b0, 39);
        drive(J, 1'b0, 50); drive(K, 1'b0, 50); drive(J, 1'b0, 61);
        drive(K, 1'b0, 50); drive(J, 1'b0, 50); drive(K, 1'b0, 50);
        drive(J, 1'b0, 50); drive(K, 1'b0, 50); drive(BAD, 1'b0, 5);
        drive(J, 1'b0, 3200);
        cmp("R5 out-of-bounds segments never complete", neg_hs, 0);
        cmp("R7 timeout falls back to FS", op_mode, 1);

        // Short reset cue: abort with no chirp (R1)
        drive(SE0, 1'b1, 1000);
        drive(J, 1'b0, 200);
        cmp("R1 abort keeps FS", op_mode, 1);
        cmp("R1 abort keeps pull-up", pullup_en, 1);

        // Full speed to high speed with glitch and boundary lengths (R4, R5)
        drive(SE0, 1'b1, WC + 250);
        drive(K, 1'b0, 1400);
        drive(SE0, 1'b0, 100);
        hub_pairs(2, 50);
        drive(BAD, 1'b0, 5);
        drive(K, 1'b0, 40); drive(J, 1'b0, 60); drive(K, 1'b0, 50);
        drive(J, 1'b0, 50); drive(K, 1'b0, 60); drive(J, 1'b0, 40);
        drive(K, 1'b0, 50);
        cmp("R8 still FS during entry delay", op_mode, 1);
        hub_pairs(2, 50);
        drive(SE0, 1'b0, 200);
        cmp("R5 restart after glitch then HS", op_mode, 2);

        // High speed to high speed through 500-cycle settle (R2, R6)
        drive(SE0, 1'b1, WC + 550);
        drive(K, 1'b0, 1400);
        drive(SE0, 1'b0, 100);
        hub_pairs(4, 55);
        drive(SE0, 1'b0, 300);
        cmp("R2 HS origin SE0 sample leads to HS again", op_mode, 2);
        cmp("R6 termination on in HS", hs_term_en, 1);

        finish_run();
    end

endmodule